// File: doc/BRIEF.md
# Multichannel Conversion Slot Scheduler

This block orders the conversions of a three-channel voltage monitor. Each channel offers two signals, a shunt measurement and a bus measurement, which together make six conversion slots. A per-channel enable vector and a two-bit signal-select mode decide which slots take part. The scheduler walks the selected slots in a fixed linear order and skips the others without spending time on them. For each slot it raises a one-cycle start strobe carrying the channel and signal identifiers. It then holds the slot for a programmed number of cycles and ends it with a one-cycle done strobe.

The length of a slot comes from one of two 3-bit conversion-time codes, one for shunt slots and one for bus slots. Both codes apply to every channel. Each code maps to `CT_BASE * (code + 1)` clock cycles, so a testbench can shrink every duration by lowering `CT_BASE`. In continuous mode the walk loops without end. In single-shot mode a trigger starts exactly one pass over the selected slots, and the block then goes idle. Configuration inputs are sampled only at slot boundaries. The converter itself is represented only by the wait count.

Top module: `conv_sequencer`

## Requirements
- R1: Slots run in ascending index order, slot index = 2*channel + signal. Channel 0 comes before 1 and 1 before 2, and within a channel the shunt slot (`slotIsBus`=0) runs before the bus slot (`slotIsBus`=1). `mode[0]` selects shunt slots and `mode[1]` selects bus slots. Slots of a disabled channel, and slots of a signal not selected, never start and take no cycles.
- R2: In continuous mode, with all channels enabled and `mode`=11, exactly five other slots start between two starts of the same slot.
- R3: In continuous mode, with all channels enabled and `mode`=01, exactly two other slots start between two starts of the same slot, and every slot is a shunt slot.
- R4: A full pass over all three channels with `mode`=11 lasts 3*(Tshunt+Tbus) cycles, from the first start strobe to the last done strobe inclusive.
- R5: A shunt slot lasts Tshunt = CT_BASE*(shuntCt+1) cycles and a bus slot lasts Tbus = CT_BASE*(busCt+1) cycles, whatever its channel. The slot length counts from the start strobe to the done strobe inclusive.
- R6: The next slot starts in the cycle right after a done strobe. With a single slot selected in continuous mode, start strobes repeat exactly every Tshunt (or Tbus) cycles.
- R7: The length of a slot does not depend on how many channels or signals are enabled.
- R8: With `continuous`=0, a `trigger` pulse while idle runs one pass over the selected slots, after which `busy` falls and no start follows. A trigger while `busy` is high is ignored. With `continuous`=1 the pass repeats without any trigger.
- R9: If no channel is enabled or `mode`=00, no start strobe is issued and `busy` stays low.
- R10: Changes to `chanEn`, `mode`, `shuntCt` or `busCt` take effect only at a slot boundary. A slot in progress keeps its length and identifiers.
- R11: While `rstN` is low, and after its release until a start condition occurs, `busy`, `startStb` and `doneStb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | NUM_CH | Per-channel enable, bit n for channel n |
| mode | input | 2 | Signal select: bit 0 shunt, bit 1 bus |
| shuntCt | input | 3 | Shunt conversion-time code |
| busCt | input | 3 | Bus conversion-time code |
| continuous | input | 1 | 1 = loop forever, 0 = single pass per trigger |
| trigger | input | 1 | Starts one pass when idle in single-shot mode |
| startStb | output | 1 | One-cycle pulse in the first cycle of a slot |
| doneStb | output | 1 | One-cycle pulse in the last cycle of a slot |
| slotChan | output | $clog2(NUM_CH) | Channel of the current slot |
| slotIsBus | output | 1 | 1 when the current slot is a bus conversion |
| busy | output | 1 | High while a slot is in progress |

## Verification
A wrong slot index shows at the next start strobe as a channel or signal out of the expected order, so a pass over the slots exposes it within one slot. A wrong down-counter load or count shows as a done strobe in the wrong cycle, or as a gap or overlap before the next start, within one slot length. A fault in the idle/busy state shows up as missing or extra start strobes after a pass ends, or when nothing is selected. The directed scenarios watch for these events over a window after each pass.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

  // Strobes from the sequencing control to the slot timer datapath.
  typedef struct packed {
    logic load;    // begin a new slot this edge
    logic active;  // a slot is currently being timed
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import convseq_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int NSLOT = 2 * NUM_CH,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [1:0]        mode,
  input  logic              continuous,
  input  logic              trigger,
  input  logic [SLOT_W-1:0] curSlot,
  input  logic              cntIsOne,
  output seqStrobe_t        strb,
  output logic [SLOT_W-1:0] nextSlot,
  output logic              busy,
  output logic              doneStb
);

  logic [NSLOT-1:0]  validVec;
  logic              anyValid;
  logic              haveAfter;
  logic [SLOT_W-1:0] firstIdx;
  logic [SLOT_W-1:0] afterIdx;
  logic              endOfSlot;
  logic              startFromIdle;
  logic              advance;

  // A slot is eligible when its channel is on and its signal is selected.
  for (genvar g = 0; g < NSLOT; g++) begin : gValid
    assign validVec[g] = chanEn[g / 2] & mode[g % 2];
  end

  // Lowest eligible slot, and lowest eligible slot after the current one.
  always_comb begin
    firstIdx  = '0;
    afterIdx  = '0;
    haveAfter = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (validVec[i]) begin
        firstIdx = SLOT_W'(i);
        if (i > int'(curSlot)) begin
          afterIdx  = SLOT_W'(i);
          haveAfter = 1'b1;
        end
      end
    end
  end

  assign anyValid      = |validVec;
  assign endOfSlot     = busy && cntIsOne;
  assign startFromIdle = !busy && (continuous || trigger) && anyValid;
  assign advance       = endOfSlot && (haveAfter || (continuous && anyValid));

  assign strb.load   = startFromIdle || advance;
  assign strb.active = busy;
  assign nextSlot    = (busy && haveAfter) ? afterIdx : firstIdx;
  assign doneStb     = endOfSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (strb.load) begin
      busy <= 1'b1;
    end else if (endOfSlot) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_timer.sv
module slot_timer
  import convseq_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int CNT_W   = 16,
  parameter int CT_BASE = 64,
  localparam int NSLOT  = 2 * NUM_CH,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [SLOT_W-1:0] nextSlot,
  input  logic [2:0]        shuntCt,
  input  logic [2:0]        busCt,
  output logic [SLOT_W-1:0] curSlot,
  output logic              cntIsOne,
  output logic              startStb,
  output logic [CH_W-1:0]   slotChan,
  output logic              slotIsBus
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] durShunt;
  logic [CNT_W-1:0] durBus;
  logic [CNT_W-1:0] durNext;

  // Conversion-time code to cycle count, scaled by CT_BASE.
  function automatic logic [CNT_W-1:0] ctCycles(input logic [2:0] code);
    return CNT_W'(CT_BASE * (int'(code) + 1));
  endfunction

  assign durShunt = ctCycles(shuntCt);
  assign durBus   = ctCycles(busCt);
  assign durNext  = nextSlot[0] ? durBus : durShunt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSlot  <= '0;
      cnt      <= '0;
      startStb <= 1'b0;
    end else if (strb.load) begin
      curSlot  <= nextSlot;
      cnt      <= durNext;
      startStb <= 1'b1;
    end else begin
      startStb <= 1'b0;
      if (strb.active && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cntIsOne  = (cnt == CNT_W'(1));
  assign slotChan  = CH_W'(curSlot >> 1);
  assign slotIsBus = curSlot[0];

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import convseq_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int CNT_W   = 16,
  parameter int CT_BASE = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH-1:0]          chanEn,
  input  logic [1:0]                 mode,
  input  logic [2:0]                 shuntCt,
  input  logic [2:0]                 busCt,
  input  logic                       continuous,
  input  logic                       trigger,
  output logic                       startStb,
  output logic                       doneStb,
  output logic [$clog2(NUM_CH)-1:0]  slotChan,
  output logic                       slotIsBus,
  output logic                       busy
);

  localparam int SLOT_W = $clog2(2 * NUM_CH);

  seqStrobe_t        strb;
  logic [SLOT_W-1:0] nextSlot;
  logic [SLOT_W-1:0] curSlot;
  logic              cntIsOne;

  seq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chanEn     (chanEn),
    .mode       (mode),
    .continuous (continuous),
    .trigger    (trigger),
    .curSlot    (curSlot),
    .cntIsOne   (cntIsOne),
    .strb       (strb),
    .nextSlot   (nextSlot),
    .busy       (busy),
    .doneStb    (doneStb)
  );

  slot_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CT_BASE(CT_BASE)) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .nextSlot  (nextSlot),
    .shuntCt   (shuntCt),
    .busCt     (busCt),
    .curSlot   (curSlot),
    .cntIsOne  (cntIsOne),
    .startStb  (startStb),
    .slotChan  (slotChan),
    .slotIsBus (slotIsBus)
  );

endmodule

// File: rtl/convseq_checker.sv
module convseq_checker #(
  parameter int NUM_CH = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_CH-1:0]         chanEn,
  input logic [1:0]                mode,
  input logic                      startStb,
  input logic                      doneStb,
  input logic [$clog2(NUM_CH)-1:0] slotChan,
  input logic                      slotIsBus,
  input logic                      busy
);

  logic [NUM_CH-1:0] prevEn;
  logic [1:0]        prevMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevEn   <= '0;
      prevMode <= '0;
    end else begin
      prevEn   <= chanEn;
      prevMode <= mode;
    end
  end

  // R1: a started slot was eligible under the configuration at its boundary
  a_r1_eligible_start: assert property (@(posedge clk) disable iff (!rstN)
    startStb |-> (((prevEn >> slotChan) & NUM_CH'(1)) != '0) && prevMode[slotIsBus]);

  // R9: nothing selected while idle means no start on the next edge
  a_r9_no_start_empty: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (chanEn == '0 || mode == 2'b00)) |=> !startStb);

  // R8: start strobes only appear inside a busy slot
  a_r8_start_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    startStb |-> busy);

  // R6: done strobe only closes a running slot
  a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> busy);

  // R10: identifiers hold for the whole slot
  a_r10_slot_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !startStb) |-> ($stable(slotChan) && $stable(slotIsBus)));

endmodule

bind conv_sequencer convseq_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chanEn    (chanEn),
  .mode      (mode),
  .startStb  (startStb),
  .doneStb   (doneStb),
  .slotChan  (slotChan),
  .slotIsBus (slotIsBus),
  .busy      (busy)
);

// File: tb/conv_sequencer_bench.sv
`timescale 1ns/1ps
module conv_sequencer_bench;

  localparam int CTB = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] chanEn = '0;
  logic [1:0] mode = '0;
  logic [2:0] shuntCt = '0;
  logic [2:0] busCt = '0;
  logic       continuous = 1'b0;
  logic       trigger = 1'b0;
  logic       startStb, doneStb, slotIsBus, busy;
  logic [1:0] slotChan;

  int cyc = 0;
  int nCmp = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_sequencer #(.NUM_CH(3), .CNT_W(16), .CT_BASE(CTB)) u_conv_sequencer (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .mode(mode), .shuntCt(shuntCt),
    .busCt(busCt), .continuous(continuous), .trigger(trigger),
    .startStb(startStb), .doneStb(doneStb), .slotChan(slotChan),
    .slotIsBus(slotIsBus), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dur(input int code);
    return CTB * (code + 1);
  endfunction

  task automatic nextStart(output int c, output int ch, output int isBus);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!startStb && n < 3000);
    chk(startStb, "start timeout", 0, 1);
    c = cyc; ch = int'(slotChan); isBus = int'(slotIsBus);
  endtask

  task automatic waitDone(output int c);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!doneStb && n < 3000);
    chk(doneStb, "done timeout", 0, 1);
    c = cyc;
  endtask

  task automatic setCfg(input logic [2:0] en, input logic [1:0] md,
                        input logic [2:0] sct, input logic [2:0] bct);
    @(negedge clk);
    chanEn = en; mode = md; shuntCt = sct; busCt = bct;
  endtask

  task automatic countStarts(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (startStb) n++;
    end
  endtask

  task automatic settle();
    int n = 0;
    @(negedge clk);
    continuous = 1'b0;
    trigger = 1'b0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    int n;
    @(negedge clk);
    chk(!busy && !startStb && !doneStb, "R11 outputs in reset", int'(busy), 0);
    rstN = 1'b1;
    countStarts(20, n);
    chk(n == 0, "R11 no start after reset release", n, 0);
    chk(!busy, "R11 busy low after release", int'(busy), 0);
  endtask

  // Single pass, all slots, trigger mid-pass ignored.
  task automatic testSinglePass();
    int c0, c, ch, b, d, n;
    setCfg(3'b111, 2'b11, 3'd1, 3'd2);
    trigger = 1'b1;
    nextStart(c, ch, b);
    trigger = 1'b0;
    c0 = c;
    chk(ch == 0 && b == 0, "R1 first slot channel 0 shunt", ch * 2 + b, 0);
    for (int k = 0; k < 6; k++) begin
      if (k == 2) begin
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
      end
      waitDone(d);
      chk(d - c + 1 == ((k % 2) ? dur(2) : dur(1)), "R5 slot length", d - c + 1,
          (k % 2) ? dur(2) : dur(1));
      if (k < 5) begin
        nextStart(c, ch, b);
        chk(c == d + 1, "R6 back-to-back start", c, d + 1);
        chk(ch * 2 + b == k + 1, "R1 slot order", ch * 2 + b, k + 1);
      end
    end
    chk(d - c0 + 1 == 3 * (dur(1) + dur(2)), "R4 pass length", d - c0 + 1,
        3 * (dur(1) + dur(2)));
    countStarts(40, n);
    chk(n == 0, "R8 single pass ends", n, 0);
    chk(!busy, "R8 idle after pass", int'(busy), 0);
  endtask

  // Continuous round robin, both signals then shunt only.
  task automatic testContinuous();
    int c[7], ch[7], b[7], others;
    setCfg(3'b111, 2'b11, 3'd0, 3'd1);
    continuous = 1'b1;
    for (int i = 0; i < 7; i++) nextStart(c[i], ch[i], b[i]);
    others = 0;
    for (int i = 1; i < 6; i++) if (ch[i] != ch[0] || b[i] != b[0]) others++;
    chk(others == 5 && ch[6] == ch[0] && b[6] == b[0], "R2 five others between repeats",
        others, 5);
    chk(c[6] - c[0] == 3 * (dur(0) + dur(1)), "R4 continuous period", c[6] - c[0],
        3 * (dur(0) + dur(1)));
    chk(c[6] - c[0] > 0, "R8 continuous loops without trigger", c[6] - c[0], 1);
    settle();
    setCfg(3'b111, 2'b01, 3'd1, 3'd1);
    continuous = 1'b1;
    for (int i = 0; i < 4; i++) nextStart(c[i], ch[i], b[i]);
    chk(ch[3] == ch[0] && b[3] == b[0] && ch[1] != ch[0] && ch[2] != ch[0],
        "R3 two others between repeats", ch[3], ch[0]);
    chk(b[0] + b[1] + b[2] + b[3] == 0, "R3 shunt only", b[0] + b[1] + b[2] + b[3], 0);
    chk(c[3] - c[0] == 3 * dur(1), "R3 shunt-only period", c[3] - c[0], 3 * dur(1));
    settle();
  endtask

  // Disabled channel and unselected signal skipped.
  task automatic testSkip();
    int c0, c, ch, b, d, n;
    setCfg(3'b101, 2'b11, 3'd1, 3'd2);
    trigger = 1'b1;
    nextStart(c, ch, b);
    trigger = 1'b0;
    c0 = c;
    chk(ch * 2 + b == 0, "R1 skip: slot 0", ch * 2 + b, 0);
    nextStart(c, ch, b);
    chk(ch * 2 + b == 1, "R1 skip: slot 1", ch * 2 + b, 1);
    nextStart(c, ch, b);
    chk(ch * 2 + b == 4, "R1 skip: channel 1 skipped", ch * 2 + b, 4);
    nextStart(c, ch, b);
    chk(ch * 2 + b == 5, "R1 skip: slot 5", ch * 2 + b, 5);
    waitDone(d);
    chk(d - c0 + 1 == 2 * (dur(1) + dur(2)), "R1 skipped channel adds no time",
        d - c0 + 1, 2 * (dur(1) + dur(2)));
    countStarts(30, n);
    chk(n == 0, "R8 skip pass ends", n, 0);
    setCfg(3'b010, 2'b10, 3'd0, 3'd0);
    trigger = 1'b1;
    nextStart(c, ch, b);
    trigger = 1'b0;
    chk(ch == 1 && b == 1, "R1 bus-only slot", ch * 2 + b, 3);
    countStarts(30, n);
    chk(n == 0, "R1 bus-only single slot", n, 0);
  endtask

  // Single slot continuous: no idle gap, length unchanged by slot count.
  task automatic testSingleSlot();
    int c[3], ch, b, d;
    setCfg(3'b010, 2'b01, 3'd3, 3'd0);
    continuous = 1'b1;
    nextStart(c[0], ch, b);
    waitDone(d);
    chk(d - c[0] + 1 == dur(3), "R7 single-slot length", d - c[0] + 1, dur(3));
    nextStart(c[1], ch, b);
    chk(c[1] == d + 1, "R6 no idle gap", c[1], d + 1);
    nextStart(c[2], ch, b);
    chk(c[2] - c[1] == dur(3), "R6 repeat period", c[2] - c[1], dur(3));
    settle();
    setCfg(3'b111, 2'b11, 3'd3, 3'd4);
    trigger = 1'b1;
    nextStart(c[0], ch, b);
    trigger = 1'b0;
    waitDone(d);
    chk(d - c[0] + 1 == dur(3), "R7 length with all enabled", d - c[0] + 1, dur(3));
    nextStart(c[1], ch, b);
    waitDone(d);
    chk(d - c[1] + 1 == dur(4), "R5 bus code independent", d - c[1] + 1, dur(4));
    settle();
  endtask

  task automatic testEmpty();
    int n;
    setCfg(3'b000, 2'b11, 3'd0, 3'd0);
    continuous = 1'b1;
    countStarts(40, n);
    chk(n == 0 && !busy, "R9 no channel enabled", n, 0);
    settle();
    setCfg(3'b111, 2'b00, 3'd0, 3'd0);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    countStarts(40, n);
    chk(n == 0 && !busy, "R9 no signal selected", n, 0);
  endtask

  // Configuration change mid-slot waits for the boundary.
  task automatic testCfgChange();
    int c, ch, b, d;
    setCfg(3'b001, 2'b01, 3'd3, 3'd0);
    continuous = 1'b1;
    nextStart(c, ch, b);
    @(negedge clk);
    shuntCt = 3'd0;
    chanEn = 3'b100;
    waitDone(d);
    chk(d - c + 1 == dur(3), "R10 running slot keeps length", d - c + 1, dur(3));
    nextStart(c, ch, b);
    chk(c == d + 1 && ch == 2, "R10 new channel at boundary", ch, 2);
    waitDone(d);
    chk(d - c + 1 == dur(0), "R10 new code at boundary", d - c + 1, dur(0));
    settle();
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testSinglePass();
    testContinuous();
    testSkip();
    testSingleSlot();
    testEmpty();
    testCfgChange();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule